// File: doc/BRIEF.md
# MII Mode Steering: Isolate, Loopback and Duplex Control

This block sits between the MII pins of a MAC and the transmit and receive paths inside a PHY. Three control bits drive it: isolate, loopback and full duplex. A PHY address strapped at reset and a speed indication also feed it. From these it decides what reaches the line, what the MAC sees on its receive pins, and how carrier sense and collision are formed.

A three-state mode machine holds the operating mode: `ST_NORMAL`, `ST_LOOP` and `ST_ISOLATE`. Reset enters `ST_ISOLATE` when the strapped address is zero and `ST_NORMAL` otherwise. On each clock the machine moves as follows. It goes to `ST_ISOLATE` while an isolate request is present, from the control bit or from the latched strap. With no isolate request and loopback set, it goes to `ST_LOOP`. With neither, it goes to `ST_NORMAL`. Isolate therefore wins over loopback. A management write of the PHY address only updates the address register. It never feeds the isolate request.

In isolate mode all MII outputs float, including both clocks, and the MAC transmit inputs are blocked from the line. In loopback, MAC transmit data is echoed to the MII receive pins and packet data is held off the line. At 100 Mb/s the line goes quiet. At 10 Mb/s link pulses continue. Line activity is shown only as a two-bit source select for the line driver.

Top module: `mii_mode_steer`

## Requirements
- R1: A high `ctl_isolate` places the block in isolate mode from the next clock edge.
- R2: A `strap_addr` of zero seen during reset puts the block in isolate mode right after reset, and it stays there until the next reset whatever the control bits or management writes.
- R3: A pulse on `addr_wr_en` loads `addr_wr_data` into `phy_addr` on the next edge and does not change the mode, even when the value written is zero.
- R4: Outside normal mode, `line_txd` is zero and `line_tx_en` and `line_tx_er` are low, whatever the MAC drives.
- R5: In isolate mode, `mii_tx_clk`, `mii_rx_clk`, `mii_rxd`, `mii_rx_dv`, `mii_rx_er`, `mii_crs` and `mii_col` are all high impedance.
- R6: In isolate mode, `line_src` is 01 (scrambled idle) when `speed_100` is high and 10 (link pulses) when it is low.
- R7: In loopback mode, `mii_rxd`, `mii_rx_dv` and `mii_rx_er` follow `mac_txd`, `mac_tx_en` and `mac_tx_er`, and `mii_rx_clk` follows `phy_tx_clk`.
- R8: In loopback mode, `line_src` is 11 (quiet) at 100 Mb/s and 10 (link pulses) at 10 Mb/s.
- R9: With `ctl_full_dup` high outside isolate, `mii_col` is low. `mii_crs` shows receive activity only: `phy_rx_crs` in normal mode, the looped `mac_tx_en` in loopback.
- R10: In half duplex, normal mode gives `mii_crs = mac_tx_en | phy_rx_crs` and `mii_col = mac_tx_en & phy_rx_crs`. Loopback gives `mii_crs = mac_tx_en` and `mii_col = 0`.
- R11: With isolate and loopback both requested, isolate mode is taken and `status[3]` stays low.
- R12: In normal mode, the line side carries the MAC transmit signals with `line_src` 00 (packet data), the MII receive pins carry the PHY receive path, and `mii_rx_clk` follows `phy_rx_clk`.
- R13: `status` bit 0 is isolate mode, bit 1 is `ctl_full_dup`, bit 2 is `speed_100` and bit 3 is loopback mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap sampled while low |
| ctl_isolate | input | 1 | Isolate request control bit |
| ctl_loopback | input | 1 | Loopback request control bit |
| ctl_full_dup | input | 1 | Full-duplex select |
| strap_addr | input | 5 | PHY address from strap pins |
| addr_wr_en | input | 1 | Management write of the PHY address |
| addr_wr_data | input | 5 | Address value for that write |
| speed_100 | input | 1 | High for 100 Mb/s, low for 10 Mb/s |
| mac_txd | input | 4 | MAC transmit data |
| mac_tx_en | input | 1 | MAC transmit enable |
| mac_tx_er | input | 1 | MAC transmit error |
| phy_tx_clk | input | 1 | Transmit clock from the PHY core |
| phy_rx_clk | input | 1 | Recovered receive clock from the PHY core |
| phy_rxd | input | 4 | Receive data from the PHY core |
| phy_rx_dv | input | 1 | Receive data valid from the PHY core |
| phy_rx_er | input | 1 | Receive error from the PHY core |
| phy_rx_crs | input | 1 | Receive carrier activity on the line |
| line_txd | output | 4 | Transmit data toward the line coder |
| line_tx_en | output | 1 | Transmit enable toward the line coder |
| line_tx_er | output | 1 | Transmit error toward the line coder |
| line_src | output | 2 | Line source: 00 packet, 01 idle, 10 link pulses, 11 quiet |
| mii_tx_clk | output | 1 | MII transmit clock (tri-state) |
| mii_rx_clk | output | 1 | MII receive clock (tri-state) |
| mii_rxd | output | 4 | MII receive data (tri-state) |
| mii_rx_dv | output | 1 | MII receive data valid (tri-state) |
| mii_rx_er | output | 1 | MII receive error (tri-state) |
| mii_crs | output | 1 | MII carrier sense (tri-state) |
| mii_col | output | 1 | MII collision (tri-state) |
| phy_addr | output | 5 | Current PHY address |
| status | output | 4 | Mode status bits |

## Verification
Several properties are checked on every clock. A set isolate bit must lead to isolate mode. A latched zero strap must keep isolate mode. Address writes must not cause isolate. Isolate must win over loopback. The line must see no transmit enable outside normal mode. Full duplex must give no collision. Loopback must echo the MAC transmit signals. Only the bench's scenarios can show the high-impedance pins, the line source codes at each speed, the half-duplex carrier and collision forms, the status layout and the loading of `phy_addr`. The bench compares these against a behavioural model on every cycle while the data inputs are randomised.

// File: rtl/mii_mode_pkg.sv
package mii_mode_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_LOOP    = 2'd1,
        ST_ISOLATE = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        SRC_PACKET = 2'b00,
        SRC_IDLE   = 2'b01,
        SRC_PULSE  = 2'b10,
        SRC_QUIET  = 2'b11
    } line_src_e;

endpackage

// File: rtl/mii_mode_fsm.sv
module mii_mode_fsm
    import mii_mode_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_isolate,
    input  logic              ctl_loopback,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              addr_wr_en,
    input  logic [ADDR_W-1:0] addr_wr_data,
    output mode_e             mode,
    output logic [ADDR_W-1:0] phy_addr
);

    logic  strap_hit;
    logic  iso_req;
    logic  strap_zero;
    mode_e mode_nxt;

    assign strap_zero = (strap_addr == '0);
    // Only the strap latch and the control bit feed isolate; phy_addr never does.
    assign iso_req    = ctl_isolate | strap_hit;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_hit <= strap_zero;
            mode      <= strap_zero ? ST_ISOLATE : ST_NORMAL;
            phy_addr  <= strap_addr;
        end else begin
            mode <= mode_nxt;
            if (addr_wr_en) begin
                phy_addr <= addr_wr_data;
            end
        end
    end

    // Next-state logic
    always_comb begin
        mode_nxt = mode;
        unique case (mode)
            ST_NORMAL: begin
                if (iso_req)           mode_nxt = ST_ISOLATE;
                else if (ctl_loopback) mode_nxt = ST_LOOP;
            end
            ST_LOOP: begin
                if (iso_req)            mode_nxt = ST_ISOLATE;
                else if (!ctl_loopback) mode_nxt = ST_NORMAL;
            end
            ST_ISOLATE: begin
                if (!iso_req) mode_nxt = ctl_loopback ? ST_LOOP : ST_NORMAL;
            end
            default: mode_nxt = ST_NORMAL;
        endcase
    end

    assert_ctl_isolate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_isolate |=> (mode == ST_ISOLATE));

    assert_strap_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strap_hit |-> (mode == ST_ISOLATE));

    assert_wr_no_isolate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr_en && !ctl_isolate && !strap_hit) |=> (mode != ST_ISOLATE));

    assert_iso_over_loop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_isolate && ctl_loopback) |=> (mode == ST_ISOLATE));

endmodule

// File: rtl/mii_tx_gate.sv
module mii_tx_gate
    import mii_mode_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic              speed_100,
    input  logic [DATA_W-1:0] mac_txd,
    input  logic              mac_tx_en,
    input  logic              mac_tx_er,
    output logic [DATA_W-1:0] line_txd,
    output logic              line_tx_en,
    output logic              line_tx_er,
    output line_src_e         line_src
);

    always_comb begin
        line_txd   = '0;
        line_tx_en = 1'b0;
        line_tx_er = 1'b0;
        line_src   = SRC_PACKET;
        unique case (mode)
            ST_NORMAL: begin
                line_txd   = mac_txd;
                line_tx_en = mac_tx_en;
                line_tx_er = mac_tx_er;
            end
            ST_LOOP:    line_src = speed_100 ? SRC_QUIET : SRC_PULSE;
            ST_ISOLATE: line_src = speed_100 ? SRC_IDLE  : SRC_PULSE;
            default:    line_src = SRC_PACKET;
        endcase
    end

    assert_tx_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != ST_NORMAL) |-> (!line_tx_en && !line_tx_er && line_txd == '0));

endmodule

// File: rtl/mii_rx_steer.sv
module mii_rx_steer
    import mii_mode_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic              full_dup,
    input  logic [DATA_W-1:0] mac_txd,
    input  logic              mac_tx_en,
    input  logic              mac_tx_er,
    input  logic              phy_tx_clk,
    input  logic              phy_rx_clk,
    input  logic [DATA_W-1:0] phy_rxd,
    input  logic              phy_rx_dv,
    input  logic              phy_rx_er,
    input  logic              phy_rx_crs,
    output logic              pin_oe,
    output logic              rx_clk_o,
    output logic [DATA_W-1:0] rxd_o,
    output logic              rx_dv_o,
    output logic              rx_er_o,
    output logic              crs_o,
    output logic              col_o
);

    logic loop_on;
    logic rx_act;

    assign loop_on = (mode == ST_LOOP);
    assign pin_oe  = (mode != ST_ISOLATE);

    // Receive path: either the PHY receive side or the echoed MAC transmit side.
    assign rx_clk_o = loop_on ? phy_tx_clk : phy_rx_clk;
    assign rxd_o    = loop_on ? mac_txd    : phy_rxd;
    assign rx_dv_o  = loop_on ? mac_tx_en  : phy_rx_dv;
    assign rx_er_o  = loop_on ? mac_tx_er  : phy_rx_er;
    assign rx_act   = loop_on ? mac_tx_en  : phy_rx_crs;

    // Carrier and collision by duplex; loopback never collides with itself.
    always_comb begin
        if (full_dup || loop_on) begin
            crs_o = rx_act;
            col_o = 1'b0;
        end else begin
            crs_o = rx_act | mac_tx_en;
            col_o = rx_act & mac_tx_en;
        end
    end

    assert_fdx_no_col_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full_dup |-> !col_o);

    assert_loop_echo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_LOOP) |-> (rxd_o == mac_txd && rx_dv_o == mac_tx_en && rx_er_o == mac_tx_er));

endmodule

// File: rtl/mii_mode_steer.sv
module mii_mode_steer
    import mii_mode_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_isolate,
    input  logic              ctl_loopback,
    input  logic              ctl_full_dup,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              addr_wr_en,
    input  logic [ADDR_W-1:0] addr_wr_data,
    input  logic              speed_100,
    input  logic [DATA_W-1:0] mac_txd,
    input  logic              mac_tx_en,
    input  logic              mac_tx_er,
    input  logic              phy_tx_clk,
    input  logic              phy_rx_clk,
    input  logic [DATA_W-1:0] phy_rxd,
    input  logic              phy_rx_dv,
    input  logic              phy_rx_er,
    input  logic              phy_rx_crs,
    output logic [DATA_W-1:0] line_txd,
    output logic              line_tx_en,
    output logic              line_tx_er,
    output logic [1:0]        line_src,
    output logic              mii_tx_clk,
    output logic              mii_rx_clk,
    output logic [DATA_W-1:0] mii_rxd,
    output logic              mii_rx_dv,
    output logic              mii_rx_er,
    output logic              mii_crs,
    output logic              mii_col,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [3:0]        status
);

    mode_e             mode;
    line_src_e         src_sel;
    logic              pin_oe;
    logic              rx_clk_i;
    logic [DATA_W-1:0] rxd_i;
    logic              rx_dv_i;
    logic              rx_er_i;
    logic              crs_i;
    logic              col_i;

    mii_mode_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_isolate  (ctl_isolate),
        .ctl_loopback (ctl_loopback),
        .strap_addr   (strap_addr),
        .addr_wr_en   (addr_wr_en),
        .addr_wr_data (addr_wr_data),
        .mode         (mode),
        .phy_addr     (phy_addr)
    );

    mii_tx_gate #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .speed_100  (speed_100),
        .mac_txd    (mac_txd),
        .mac_tx_en  (mac_tx_en),
        .mac_tx_er  (mac_tx_er),
        .line_txd   (line_txd),
        .line_tx_en (line_tx_en),
        .line_tx_er (line_tx_er),
        .line_src   (src_sel)
    );

    mii_rx_steer #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .full_dup   (ctl_full_dup),
        .mac_txd    (mac_txd),
        .mac_tx_en  (mac_tx_en),
        .mac_tx_er  (mac_tx_er),
        .phy_tx_clk (phy_tx_clk),
        .phy_rx_clk (phy_rx_clk),
        .phy_rxd    (phy_rxd),
        .phy_rx_dv  (phy_rx_dv),
        .phy_rx_er  (phy_rx_er),
        .phy_rx_crs (phy_rx_crs),
        .pin_oe     (pin_oe),
        .rx_clk_o   (rx_clk_i),
        .rxd_o      (rxd_i),
        .rx_dv_o    (rx_dv_i),
        .rx_er_o    (rx_er_i),
        .crs_o      (crs_i),
        .col_o      (col_i)
    );

    assign line_src = src_sel;

    // MII output drivers: released to high impedance in isolate mode.
    assign mii_tx_clk = pin_oe ? phy_tx_clk : 1'bz;
    assign mii_rx_clk = pin_oe ? rx_clk_i   : 1'bz;
    assign mii_rxd    = pin_oe ? rxd_i      : {DATA_W{1'bz}};
    assign mii_rx_dv  = pin_oe ? rx_dv_i    : 1'bz;
    assign mii_rx_er  = pin_oe ? rx_er_i    : 1'bz;
    assign mii_crs    = pin_oe ? crs_i      : 1'bz;
    assign mii_col    = pin_oe ? col_i      : 1'bz;

    // Bit 3 of the status word carries the loopback state.
    assign status = {(mode == ST_LOOP), speed_100, ctl_full_dup, (mode == ST_ISOLATE)};

endmodule

// File: tb/mii_mode_steer_test.sv
module mii_mode_steer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_isolate = 1'b0, ctl_loopback = 1'b0, ctl_full_dup = 1'b0;
    logic [4:0] strap_addr = 5'd3;
    logic       addr_wr_en = 1'b0;
    logic [4:0] addr_wr_data = 5'd0;
    logic       speed_100 = 1'b1;
    logic [3:0] mac_txd = 4'd0;
    logic       mac_tx_en = 1'b0, mac_tx_er = 1'b0;
    logic       phy_tx_clk = 1'b0, phy_rx_clk = 1'b0;
    logic [3:0] phy_rxd = 4'd0;
    logic       phy_rx_dv = 1'b0, phy_rx_er = 1'b0, phy_rx_crs = 1'b0;
    logic [3:0] line_txd;
    logic       line_tx_en, line_tx_er;
    logic [1:0] line_src;
    logic       mii_tx_clk, mii_rx_clk;
    logic [3:0] mii_rxd;
    logic       mii_rx_dv, mii_rx_er, mii_crs, mii_col;
    logic [4:0] phy_addr;
    logic [3:0] status;

    always #5 clk = ~clk;

    mii_mode_steer uut (
        .clk(clk), .rst_n(rst_n),
        .ctl_isolate(ctl_isolate), .ctl_loopback(ctl_loopback), .ctl_full_dup(ctl_full_dup),
        .strap_addr(strap_addr), .addr_wr_en(addr_wr_en), .addr_wr_data(addr_wr_data),
        .speed_100(speed_100), .mac_txd(mac_txd), .mac_tx_en(mac_tx_en), .mac_tx_er(mac_tx_er),
        .phy_tx_clk(phy_tx_clk), .phy_rx_clk(phy_rx_clk), .phy_rxd(phy_rxd),
        .phy_rx_dv(phy_rx_dv), .phy_rx_er(phy_rx_er), .phy_rx_crs(phy_rx_crs),
        .line_txd(line_txd), .line_tx_en(line_tx_en), .line_tx_er(line_tx_er), .line_src(line_src),
        .mii_tx_clk(mii_tx_clk), .mii_rx_clk(mii_rx_clk), .mii_rxd(mii_rxd),
        .mii_rx_dv(mii_rx_dv), .mii_rx_er(mii_rx_er), .mii_crs(mii_crs), .mii_col(mii_col),
        .phy_addr(phy_addr), .status(status)
    );

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    // Reference model: mode 0 normal, 1 loopback, 2 isolate
    int   m_mode = 0;
    bit   m_strap = 1'b0;
    bit   m_valid = 1'b0;
    logic [4:0] m_addr = 5'd0;

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic compare_all();
        bit    iso, lp;
        string rq_pin, rq_dup, rq_line;
        iso = (m_mode == 2);
        lp  = (m_mode == 1);
        rq_pin  = iso ? "R5" : (lp ? "R7" : "R12");
        rq_dup  = ctl_full_dup ? "R9" : "R10";
        rq_line = iso ? "R6" : (lp ? "R8" : "R12");
        if (iso) begin
            chk(rq_pin, "tx_clk", {7'd0, mii_tx_clk}, {7'd0, 1'bz});
            chk(rq_pin, "rx_clk", {7'd0, mii_rx_clk}, {7'd0, 1'bz});
            chk(rq_pin, "rxd", {4'd0, mii_rxd}, {4'd0, 4'bzzzz});
            chk(rq_pin, "dv/er", {6'd0, mii_rx_dv, mii_rx_er}, {6'd0, 2'bzz});
            chk(rq_pin, "crs/col", {6'd0, mii_crs, mii_col}, {6'd0, 2'bzz});
        end else if (lp) begin
            chk(rq_pin, "tx_clk", {7'd0, mii_tx_clk}, {7'd0, phy_tx_clk});
            chk(rq_pin, "rx_clk", {7'd0, mii_rx_clk}, {7'd0, phy_tx_clk});
            chk(rq_pin, "rxd/dv/er", {2'd0, mii_rxd, mii_rx_dv, mii_rx_er}, {2'd0, mac_txd, mac_tx_en, mac_tx_er});
            chk(rq_dup, "loop crs/col", {6'd0, mii_crs, mii_col}, {6'd0, mac_tx_en, 1'b0});
        end else begin
            chk(rq_pin, "tx_clk", {7'd0, mii_tx_clk}, {7'd0, phy_tx_clk});
            chk(rq_pin, "rx_clk", {7'd0, mii_rx_clk}, {7'd0, phy_rx_clk});
            chk(rq_pin, "rxd/dv/er", {2'd0, mii_rxd, mii_rx_dv, mii_rx_er}, {2'd0, phy_rxd, phy_rx_dv, phy_rx_er});
            if (ctl_full_dup)
                chk(rq_dup, "crs/col", {6'd0, mii_crs, mii_col}, {6'd0, phy_rx_crs, 1'b0});
            else
                chk(rq_dup, "crs/col", {6'd0, mii_crs, mii_col},
                    {6'd0, mac_tx_en | phy_rx_crs, mac_tx_en & phy_rx_crs});
        end
        if (m_mode == 0) begin
            chk("R12", "line tx", {2'd0, line_txd, line_tx_en, line_tx_er}, {2'd0, mac_txd, mac_tx_en, mac_tx_er});
            chk("R12", "line_src", {6'd0, line_src}, 8'd0);
        end else begin
            chk("R4", "line tx blocked", {2'd0, line_txd, line_tx_en, line_tx_er}, 8'd0);
            chk(rq_line, "line_src", {6'd0, line_src},
                iso ? (speed_100 ? 8'd1 : 8'd2) : (speed_100 ? 8'd3 : 8'd2));
        end
        chk("R13", "status", {4'd0, status}, {4'd0, lp, speed_100, ctl_full_dup, iso});
        chk("R3", "phy_addr", {3'd0, phy_addr}, {3'd0, m_addr});
    endtask

    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            m_strap = (strap_addr == 5'd0);
            m_mode  = m_strap ? 2 : 0;
            m_addr  = strap_addr;
            m_valid = 1'b1;
        end else begin
            m_mode = (ctl_isolate || m_strap) ? 2 : (ctl_loopback ? 1 : 0);
            if (addr_wr_en) m_addr = addr_wr_data;
        end
        #2;
        {mac_txd, mac_tx_en, mac_tx_er} = 6'($urandom);
        {phy_rxd, phy_rx_dv, phy_rx_er, phy_rx_crs} = 7'($urandom);
        {phy_tx_clk, phy_rx_clk} = 2'($urandom);
        #1;
        if (m_valid && !done) compare_all();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        run(3);
        rst_n = 1'b1;
        step();
        chk("R12", "reset leaves normal mode", {4'd0, status}, {4'd0, 1'b0, speed_100, 1'b0, 1'b0});
        run(30);                       // R10 half duplex, normal, 100
        ctl_full_dup = 1'b1; run(30);  // R9
        speed_100 = 1'b0;    run(20);
        ctl_full_dup = 1'b0; ctl_loopback = 1'b1; run(30);   // R8 10 Mb/s loop
        speed_100 = 1'b1;    run(20);                        // R8 100 Mb/s loop
        ctl_full_dup = 1'b1; run(15);
        ctl_loopback = 1'b0; ctl_isolate = 1'b1; step();
        chk("R1", "isolate after control bit", {7'd0, status[0]}, 8'd1);
        run(20);
        speed_100 = 1'b0; run(20);     // R6 link pulses
        ctl_loopback = 1'b1; step();
        chk("R11", "isolate wins over loopback", {6'd0, status[3], status[0]}, 8'd1);
        run(15);
        ctl_isolate = 1'b0; ctl_loopback = 1'b0; step();
        addr_wr_en = 1'b1; addr_wr_data = 5'd0; step();
        addr_wr_en = 1'b0; step();
        chk("R3", "addr write of zero no isolate", {3'd0, phy_addr, status[0]}, 8'd0);
        run(10);
        strap_addr = 5'd0; rst_n = 1'b0; run(3);
        rst_n = 1'b1; strap_addr = 5'd9; step();
        chk("R2", "strap zero isolates", {7'd0, status[0]}, 8'd1);
        ctl_loopback = 1'b1; run(15);
        addr_wr_en = 1'b1; addr_wr_data = 5'd7; step();
        addr_wr_en = 1'b0; run(5);
        chk("R2", "strap isolate persists", {7'd0, status[0]}, 8'd1);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule